// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction per clock. It supports a small subset of instructions: word load and word store, register add, subtract, AND, OR and signed set-less-than, branch-if-equal, and an absolute jump. The core holds the program counter, a 32-entry register file, a sign extender, an ALU and the next-address logic. Decoding is done in two levels. A main decoder turns the opcode into datapath controls and a 2-bit ALU class. A small local decoder then turns that class, together with the function field, into a 4-bit ALU operation code.

The instruction memory is read asynchronously at the program counter. The data memory port also has a combinational read path. The data address, the store data and the read and write strobes come straight from the current instruction. Register-file and program-counter state changes only on the rising clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the program counter (`imem_addr`) is 0. The first instruction fetched after release is at address 0.
- R2: Register-format instructions (opcode 0) with funct 100000 add, 100010 subtract, 100100 AND and 100101 OR combine R[bits 25:21] with R[bits 20:16]. The result is written to R[bits 15:11].
- R3: Funct 101010 compares its two operands as signed values and writes 1 if the first is less, otherwise 0.
- R4: Opcode 35 asserts `dmem_rd`, drives `dmem_addr` = R[25:21] + sign-extended bits 15:0, and writes `dmem_rdata` into R[20:16].
- R5: Opcode 43 asserts `dmem_wr` with `dmem_addr` = R[25:21] + sign-extended bits 15:0 and `dmem_wdata` = R[20:16]. It writes no register.
- R6: Opcode 4 compares R[25:21] with R[20:16]. If they are equal, the next PC is PC+4+(sign-extended imm16 shifted left by 2). Otherwise the next PC is PC+4. No register or memory is written.
- R7: Opcode 2 sets the next PC to bits 31:28 of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R8: Register 0 always reads as zero. Writes aimed at it are discarded.
- R9: Any other opcode writes no register and no memory, and the PC advances by 4.
- R10: Every instruction other than a taken branch or a jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe, sampled at the rising edge |
| dmem_rdata | input | 32 | Data read at `dmem_addr` |

## Verification
The data-port strobes, address and store data are combinational functions of the instruction being fetched. They are due in the same cycle as that instruction. A register result becomes visible one edge later, and the bench observes it through a later store's data. The new PC appears on `imem_addr` right after the next rising edge. The bench reference model steps once per clock and compares all of these at the falling edge. At that point every register on the path has settled from the previous rising edge, and the current instruction has not yet been committed.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN    = 32;
  localparam int REG_CNT = 32;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_code_e;

  typedef enum logic [1:0] {
    CLS_MEM  = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_REG  = 2'b10,
    CLS_NONE = 2'b11
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_rd;
    logic     mem_we;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '{dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0, reg_we: 1'b0,
            mem_rd: 1'b0, mem_we: 1'b0, branch: 1'b0, jump: 1'b0,
            cls: CLS_MEM};
    case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.cls    = CLS_REG;
      end
      OPC_LOAD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_CMP;
      end
      OPC_JUMP: ctl.jump = 1'b1;
      default:  ctl.cls  = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_code_e  code
);
  always_comb begin
    case (cls)
      CLS_CMP: code = ALU_SUB;
      CLS_REG: begin
        case (funct)
          FN_SUB:  code = ALU_SUB;
          FN_AND:  code = ALU_AND;
          FN_OR:   code = ALU_OR;
          FN_SLT:  code = ALU_SLT;
          default: code = ALU_ADD;
        endcase
      end
      default: code = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_code_e    code,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    case (code)
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      ALU_NOR: res = ~(opa | opb);
      default: res = '0;
    endcase
  end
  assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] wa,
  input  logic          we,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs_q [N];
  logic [N-1:0] row_en;

  for (genvar g = 0; g < N; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign row_en[g] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= '0;
        else        regs_q[g] <= '0;
      end
    end else begin : g_live
      assign row_en[g] = we && (wa == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          regs_q[g] <= '0;
        else if (row_en[g])  regs_q[g] <= wd;
      end
    end
  end

  assign rd1 = regs_q[ra1];
  assign rd2 = regs_q[ra2];

  // R2
  wb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> (ra1 != $past(wa)) || (rd1 == $past(wd)));
  // R8
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == '0) |=> (ra2 != '0) || (rd2 == '0));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_rd,
  output logic        dmem_wr,
  input  logic [31:0] dmem_rdata
);
  localparam int RAW = $clog2(REG_CNT);

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt, imm_ext;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  logic            alu_zero, take_br;
  ctrl_t           ctl;
  alu_code_e       alu_code;

  assign rs_idx  = imem_rdata[25:21];
  assign rt_idx  = imem_rdata[20:16];
  assign rd_idx  = imem_rdata[15:11];
  assign imm_ext = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  sc_main_dec u_main (.opcode(imem_rdata[31:26]), .ctl(ctl));
  sc_alu_dec  u_adec (.cls(ctl.cls), .funct(imem_rdata[5:0]), .code(alu_code));

  assign wr_idx = ctl.dst_rd ? rd_idx : rt_idx;
  assign wb_val = ctl.wb_mem ? dmem_rdata : alu_y;

  sc_regfile #(.W(XLEN), .N(REG_CNT)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra1(rs_idx), .ra2(rt_idx), .wa(wr_idx),
    .we(ctl.reg_we), .wd(wb_val), .rd1(rs_val), .rd2(rt_val)
  );

  assign alu_b = ctl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .opa(rs_val), .opb(alu_b), .code(alu_code), .res(alu_y), .zero(alu_zero)
  );

  // next-address selection
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[XLEN-1:28], imem_rdata[25:0], 2'b00};
  assign take_br  = ctl.branch & alu_zero;

  always_comb begin
    pc_d = pc_plus4;
    if (ctl.jump)     pc_d = jmp_tgt;
    else if (take_br) pc_d = br_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_rd    = ctl.mem_rd;
  assign dmem_wr    = ctl.mem_we;

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.jump && !(ctl.branch && alu_zero)) |=> (pc_q == $past(pc_q) + 32'd4));
  // R6
  br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.branch && rs_val == rt_val) |=>
      (pc_q == $past(pc_q) + 32'd4 + {$past(imm_ext[29:0]), 2'b00}));
  // R7
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jump |=> (pc_q == {$past(pc_plus4[31:28]), $past(imem_rdata[25:0]), 2'b00}));
  // R5
  store_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |-> !dmem_rd && !ctl.reg_we);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  logic [31:0] m_regs [32];
  string       wtag [32];
  string       prev_tag;
  logic [31:0] m_pc;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (rst_n && dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_regs[i] = 32'd0;
      wtag[i]   = (i == 0) ? "R8" : "R1";
    end
    m_pc     = 32'd0;
    prev_tag = "R1";
  endtask

  task automatic step();
    logic [31:0] ins, a, b, sx, addr, nxt, wval;
    logic        e_rd, e_wr, wen;
    int          rs, rt, widx;
    string       cls;
    ins  = imem[m_pc[7:2]];
    rs   = int'(ins[25:21]);
    rt   = int'(ins[20:16]);
    sx   = {{16{ins[15]}}, ins[15:0]};
    a    = m_regs[rs];
    b    = m_regs[rt];
    addr = a + sx;
    nxt  = m_pc + 32'd4;
    e_rd = 1'b0; e_wr = 1'b0; wen = 1'b0; widx = 0; wval = 32'd0;
    chk(prev_tag, imem_addr, m_pc, "pc");
    case (ins[31:26])
      6'd0: begin
        wen = 1'b1; widx = int'(ins[15:11]); cls = "R2";
        case (ins[5:0])
          6'b100010: wval = a - b;
          6'b100100: wval = a & b;
          6'b100101: wval = a | b;
          6'b101010: begin wval = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; cls = "R3"; end
          default:   wval = a + b;
        endcase
      end
      6'd35: begin e_rd = 1'b1; wen = 1'b1; widx = rt; wval = dmem[addr[7:2]]; cls = "R4"; end
      6'd43: begin e_wr = 1'b1; cls = "R5"; end
      6'd4: begin
        cls = "R6";
        if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
      end
      6'd2: begin
        cls = "R7";
        nxt = {m_pc[31:28] + 4'(m_pc[27:0] > 28'hFFFFFFB), ins[25:0], 2'b00};
        nxt[31:28] = (m_pc + 32'd4) >> 28;
      end
      default: cls = "R9";
    endcase
    chk(cls, {31'd0, dmem_rd}, {31'd0, e_rd}, "dmem_rd");
    chk(cls, {31'd0, dmem_wr}, {31'd0, e_wr}, "dmem_wr");
    if (e_wr) begin
      chk("R5", dmem_addr, addr, "store address");
      chk(wtag[rt], dmem_wdata, b, "store data");
    end
    if (e_rd) chk("R4", dmem_addr, addr, "load address");
    if (wen && widx != 0) begin
      m_regs[widx] = wval;
      wtag[widx]   = cls;
    end
    prev_tag = (cls == "R6" || cls == "R7" || cls == "R9") ? cls : "R10";
    m_pc = nxt;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc_i(6'd43, 0, 1, 40);
      dmem[i] = 32'd0;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFF0;
    imem[0]  = enc_i(6'd35, 0, 1, 0);
    imem[1]  = enc_i(6'd35, 0, 2, 4);
    imem[2]  = enc_r(1, 2, 3, 6'b100000);
    imem[3]  = enc_r(1, 2, 4, 6'b100010);
    imem[4]  = enc_r(1, 2, 5, 6'b100100);
    imem[5]  = enc_r(1, 2, 6, 6'b100101);
    imem[6]  = enc_r(2, 1, 7, 6'b101010);
    imem[7]  = enc_r(1, 2, 8, 6'b101010);
    imem[8]  = enc_r(1, 1, 0, 6'b100000);
    imem[9]  = enc_i(6'd43, 0, 3, 8);
    imem[10] = enc_i(6'd43, 0, 4, 12);
    imem[11] = enc_i(6'd43, 0, 5, 16);
    imem[12] = enc_i(6'd43, 0, 6, 20);
    imem[13] = enc_i(6'd43, 0, 7, 24);
    imem[14] = enc_i(6'd43, 0, 8, 28);
    imem[15] = enc_i(6'd43, 0, 0, 32);
    imem[16] = enc_i(6'h3F, 1, 9, 1);
    imem[17] = enc_i(6'd43, 0, 9, 36);
    imem[18] = enc_i(6'd4, 1, 2, 5);
    imem[19] = enc_i(6'd4, 1, 1, 2);
    imem[22] = {6'd2, 26'd25};
    imem[25] = enc_i(6'd4, 5, 0, 1);
    imem[27] = enc_i(6'd4, 0, 0, -1);

    rst_n = 1'b0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      chk("R1", imem_addr, 32'd0, "pc in reset");
    end
    rst_n = 1'b1;
    step();
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      step();
    end
    rst_n = 1'b0;
    #1;
    chk("R1", imem_addr, 32'd0, "pc after mid-run reset");
    @(negedge clk);
    chk("R1", imem_addr, 32'd0, "pc held in reset");
    model_reset();
    rst_n = 1'b1;
    step();
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule